// File: doc/BRIEF.md
# Speculative Store Buffer with Commit and Squash

This block sits between an execution core and a slower memory write port. Each store comes in with a flag that marks it as speculative and with a small speculation tag. A speculative store is held inside the buffer and is not seen by memory until the core commits its tag. If the core squashes the tag, the store is thrown away and causes no memory traffic. A non-speculative store enters already committed. Committed stores leave in the order they arrived, one word-wide write per accepted handshake.

Stores may be one to four bytes long and may sit at any byte address. The buffer turns each store into word-aligned writes with per-byte enables and splits a store that crosses a word boundary into two entries. A run of speculative narrow stores with the same tag to the same word is gathered into one entry, so it costs one memory write. The most significant address bit marks the I/O space. A speculative store that touches it is held off at the input until the core presents it as non-speculative. A load port looks up buffered data by word address for cacheable words only.

Top module: `spec_store_buf`

## Requirements
- R1: A store accepted with `st_spec`=1 produces no memory write while its tag is uncommitted. A commit of tag T marks as committed every buffered uncommitted entry with tag T, starting in the cycle after the commit is presented. A store accepted in that same cycle is not affected.
- R2: A squash of tag T removes every buffered uncommitted entry with tag T. Those entries never appear on the memory port and no longer answer load lookups. A later commit of T has no effect on them.
- R3: A speculative store that does not cross a word merges into the youngest entry when that entry holds the same word, carries the same tag, is uncommitted and sees no commit or squash of that tag in the same cycle. Newer bytes replace older ones, so four byte stores to one word drain as one write with all four enables set.
- R4: `st_addr` is a byte address. `st_len` holds the byte count minus one. The store bytes sit in the low bytes of `st_data`, least significant byte first. Byte k of the store goes to lane (`st_addr`[1:0]+k), and lane i is `mem_data`[8i+7:8i] with enable `mem_be`[i]. Lanes 4 to 7 go to the next word, which is written after the lower word. Disabled lanes read zero. A drained write always has at least one enable set.
- R5: A store with `st_spec`=1 that touches any byte whose address has bit 31 set is refused (`st_ready`=0). The same store with `st_spec`=0 is accepted and written.
- R6: A load lookup on a word address with bit 29 clear reports a hit, and it returns the data and byte mask of the youngest live entry holding that word. A lookup on an I/O word (bit 29 set) never hits.
- R7: Committed entries drain in arrival order. An uncommitted oldest entry blocks all younger ones. While `mem_valid` is high and `mem_ready` is low, the address, data and enables stay stable.
- R8: The buffer holds DEPTH (default 8) entries. A squashed entry keeps its slot until it reaches the head. `st_ready` is low unless there is one free slot for a store within one word or two free slots for a word-crossing store. A merging store needs no free slot.
- R9: A commit and a squash of different tags in the same cycle both take effect. A commit and a squash of the same tag in one cycle is illegal.
- R10: After reset the buffer is empty: `mem_valid`=0, `ld_hit`=0, and `st_ready`=1 for a cacheable store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | 32 | Store byte address |
| st_len | input | 2 | Store length in bytes minus one |
| st_data | input | 32 | Store data, low bytes first |
| st_spec | input | 1 | Store depends on an open speculation |
| st_tag | input | TAG_W (3) | Speculation tag of the store |
| cm_valid | input | 1 | Commit a speculation tag |
| cm_tag | input | TAG_W (3) | Tag to commit |
| sq_valid | input | 1 | Squash a speculation tag |
| sq_tag | input | TAG_W (3) | Tag to squash |
| ld_waddr | input | 30 | Load lookup word address |
| ld_hit | output | 1 | Lookup found a buffered cacheable word |
| ld_data | output | 32 | Forwarded word data |
| ld_mask | output | 4 | Valid byte lanes of ld_data |
| mem_valid | output | 1 | Memory write pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Word-aligned memory write address |
| mem_data | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |

## Verification
The assertions check several rules on every cycle: a commit and a squash never name the same tag together, a stalled drain holds its write stable, occupancy never goes past the depth, no buffered entry in I/O space is uncommitted, drained writes carry an enable, and I/O lookups never hit. Other behaviour shows only through the bench's scenarios. These are the hold-until-commit and squash outcomes, byte gathering into a single write, the lane and split layout over every offset and length, order blocking behind an uncommitted head, youngest-entry forwarding, and the exact fill level at which the input stops accepting one-slot and two-slot stores.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = 8 * WORD_BYTES;
    localparam int OFF_W      = $clog2(WORD_BYTES);
    localparam int WA_W       = ADDR_W - OFF_W;

    typedef logic [WA_W-1:0] waddr_t;

    // one aligned word-sized piece of a store
    typedef struct packed {
        waddr_t                  wa;
        logic [DATA_W-1:0]       data;
        logic [WORD_BYTES-1:0]   be;
    } piece_t;

    // one buffer slot
    typedef struct packed {
        logic                    vld;
        logic                    cmt;
        waddr_t                  wa;
        logic [DATA_W-1:0]       data;
        logic [WORD_BYTES-1:0]   be;
    } slot_t;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0]     old_d,
        input logic [DATA_W-1:0]     new_d,
        input logic [WORD_BYTES-1:0] sel
    );
        logic [DATA_W-1:0] r;
        r = old_d;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (sel[b]) r[8*b +: 8] = new_d[8*b +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/ssb_align.sv
module ssb_align
    import ssb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        len,
    input  logic [DATA_W-1:0] data,
    output piece_t            lo,
    output piece_t            hi,
    output logic              split
);
    logic [OFF_W-1:0]          off;
    logic [2*WORD_BYTES-1:0]   len_mask;
    logic [2*WORD_BYTES-1:0]   wide_be;
    logic [2*DATA_W-1:0]       wide_d;
    logic [DATA_W-1:0]         dmask;

    always_comb begin
        off      = addr[OFF_W-1:0];
        len_mask = '0;
        dmask    = '0;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (b <= int'(len)) begin
                len_mask[b]      = 1'b1;
                dmask[8*b +: 8]  = data[8*b +: 8];
            end
        end
        wide_be  = len_mask << off;
        wide_d   = {{DATA_W{1'b0}}, dmask} << (8 * off);
        lo.wa    = addr[ADDR_W-1:OFF_W];
        lo.data  = wide_d[DATA_W-1:0];
        lo.be    = wide_be[WORD_BYTES-1:0];
        hi.wa    = addr[ADDR_W-1:OFF_W] + 1'b1;
        hi.data  = wide_d[2*DATA_W-1:DATA_W];
        hi.be    = wide_be[2*WORD_BYTES-1:WORD_BYTES];
        split    = |wide_be[2*WORD_BYTES-1:WORD_BYTES];
    end
endmodule

// File: rtl/ssb_fwd.sv
module ssb_fwd
    import ssb_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PW    = $clog2(DEPTH)
) (
    input  slot_t [DEPTH-1:0]     slots,
    input  logic [PW:0]           head,
    input  logic [PW:0]           occ,
    input  waddr_t                ld_wa,
    output logic                  hit,
    output logic [DATA_W-1:0]     data,
    output logic [WORD_BYTES-1:0] mask
);
    logic [PW-1:0] idx;

    // walk oldest to youngest; the last match wins
    always_comb begin
        hit  = 1'b0;
        data = '0;
        mask = '0;
        idx  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head[PW-1:0] + PW'(i);
            if (i < int'(occ) && slots[idx].vld && slots[idx].wa == ld_wa
                && !ld_wa[WA_W-1]) begin
                hit  = 1'b1;
                data = slots[idx].data;
                mask = slots[idx].be;
            end
        end
    end
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
    import ssb_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int TAG_W = 3,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [1:0]            st_len,
    input  logic [DATA_W-1:0]     st_data,
    input  logic                  st_spec,
    input  logic [TAG_W-1:0]      st_tag,
    input  logic                  cm_valid,
    input  logic [TAG_W-1:0]      cm_tag,
    input  logic                  sq_valid,
    input  logic [TAG_W-1:0]      sq_tag,
    input  logic [WA_W-1:0]       ld_waddr,
    output logic                  ld_hit,
    output logic [DATA_W-1:0]     ld_data,
    output logic [WORD_BYTES-1:0] ld_mask,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_data,
    output logic [WORD_BYTES-1:0] mem_be
);
    slot_t [DEPTH-1:0] slots;
    logic [TAG_W-1:0]  tags [DEPTH];
    logic [PW:0]       head, tail, occ, free_n, need;
    logic [PW-1:0]     hidx, tidx, tidx1, yidx;
    piece_t            lo_p, hi_p;
    logic              split, io_touch, tag_busy, can_merge, st_fire, pop;

    ssb_align u_align (
        .addr  (st_addr),
        .len   (st_len),
        .data  (st_data),
        .lo    (lo_p),
        .hi    (hi_p),
        .split (split)
    );

    ssb_fwd #(.DEPTH(DEPTH)) u_fwd (
        .slots (slots),
        .head  (head),
        .occ   (occ),
        .ld_wa (ld_waddr),
        .hit   (ld_hit),
        .data  (ld_data),
        .mask  (ld_mask)
    );

    always_comb begin
        occ      = tail - head;
        free_n   = (PW+1)'(DEPTH) - occ;
        hidx     = head[PW-1:0];
        tidx     = tail[PW-1:0];
        tidx1    = tidx + 1'b1;
        yidx     = tidx - 1'b1;
        need     = split ? (PW+1)'(2) : (PW+1)'(1);
        io_touch = lo_p.wa[WA_W-1] || (split && hi_p.wa[WA_W-1]);
        tag_busy = (cm_valid && cm_tag == st_tag) || (sq_valid && sq_tag == st_tag);
        can_merge = st_spec && !split && (occ != '0) && slots[yidx].vld
                    && !slots[yidx].cmt && tags[yidx] == st_tag
                    && slots[yidx].wa == lo_p.wa && !tag_busy;
        st_ready = !(st_spec && io_touch) && (can_merge || free_n >= need);
        st_fire  = st_valid && st_ready;
        mem_valid = (occ != '0) && slots[hidx].vld && slots[hidx].cmt;
        mem_addr  = {slots[hidx].wa, {OFF_W{1'b0}}};
        mem_data  = slots[hidx].data;
        mem_be    = slots[hidx].be;
        pop       = (occ != '0) && (!slots[hidx].vld || (mem_valid && mem_ready));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            slots <= '0;
            for (int i = 0; i < DEPTH; i++) tags[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slots[i].vld && !slots[i].cmt) begin
                    if (cm_valid && tags[i] == cm_tag) slots[i].cmt <= 1'b1;
                    if (sq_valid && tags[i] == sq_tag) slots[i].vld <= 1'b0;
                end
            end
            if (pop) begin
                slots[hidx].vld <= 1'b0;
                head            <= head + 1'b1;
            end
            if (st_fire) begin
                if (can_merge) begin
                    slots[yidx].data <= lane_merge(slots[yidx].data, lo_p.data, lo_p.be);
                    slots[yidx].be   <= slots[yidx].be | lo_p.be;
                end else begin
                    slots[tidx] <= '{vld: 1'b1, cmt: ~st_spec, wa: lo_p.wa,
                                     data: lo_p.data, be: lo_p.be};
                    tags[tidx]  <= st_tag;
                    if (split) begin
                        slots[tidx1] <= '{vld: 1'b1, cmt: ~st_spec, wa: hi_p.wa,
                                          data: hi_p.data, be: hi_p.be};
                        tags[tidx1]  <= st_tag;
                    end
                    tail <= tail + need;
                end
            end
        end
    end

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        (cm_valid && sq_valid) |-> (cm_tag != sq_tag)); // R9

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be))); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= (PW+1)'(DEPTH)); // R8

    AST_BE_PRESENT: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_be != '0)); // R4

    AST_IO_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        ld_waddr[WA_W-1] |-> !ld_hit); // R6

    for (genvar g = 0; g < DEPTH; g++) begin : g_io_chk
        AST_IO_COMMITTED: assert property (@(posedge clk) disable iff (rst)
            (slots[g].vld && slots[g].wa[WA_W-1]) |-> slots[g].cmt); // R5
    end
endmodule

// File: tb/sim_spec_store_buf.sv
module sim_spec_store_buf;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0, st_spec = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0, st_data = '0;
    logic [1:0]  st_len = '0;
    logic [2:0]  st_tag = '0, cm_tag = '0, sq_tag = '0;
    logic        cm_valid = 1'b0, sq_valid = 1'b0;
    logic [29:0] ld_waddr = '0;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic [3:0]  ld_mask;
    logic        mem_valid, mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_data;
    logic [3:0]  mem_be;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] log_addr [$];
    logic [31:0] log_data [$];
    logic [3:0]  log_be   [$];

    spec_store_buf u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_len(st_len), .st_data(st_data), .st_spec(st_spec),
        .st_tag(st_tag), .cm_valid(cm_valid), .cm_tag(cm_tag), .sq_valid(sq_valid),
        .sq_tag(sq_tag), .ld_waddr(ld_waddr), .ld_hit(ld_hit), .ld_data(ld_data),
        .ld_mask(ld_mask), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // inputs change just after the rising edge, so mid-cycle values are what the edge sees
    always @(negedge clk) begin
        if (!rst && mem_valid && mem_ready) begin
            log_addr.push_back(mem_addr);
            log_data.push_back(mem_data);
            log_be.push_back(mem_be);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        log_addr.delete();
        log_data.delete();
        log_be.delete();
    endtask

    task automatic chk_log(input int i, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] be, input string req);
        if (i >= log_addr.size()) begin
            chk(1'b0, req, 64'(log_addr.size()), 64'(i + 1));
        end else begin
            chk(log_addr[i] == a, req, 64'(log_addr[i]), 64'(a));
            chk(log_data[i] == d && log_be[i] == be, req,
                {28'd0, log_be[i], log_data[i]}, {28'd0, be, d});
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_store(input logic [31:0] a, input logic [1:0] l, input logic [31:0] d,
                            input logic sp, input logic [2:0] t);
        st_valid = 1'b1; st_addr = a; st_len = l; st_data = d; st_spec = sp; st_tag = t;
        @(negedge clk);
        for (int k = 0; k < 50 && !st_ready; k++) @(negedge clk);
        @(posedge clk);
        #1;
        st_valid = 1'b0;
    endtask

    task automatic probe_ready(input logic [31:0] a, input logic [1:0] l, input logic sp,
                               input logic exp, input string req);
        st_valid = 1'b0; st_addr = a; st_len = l; st_spec = sp; st_tag = 3'd0;
        @(negedge clk);
        chk(st_ready == exp, req, 64'(st_ready), 64'(exp));
        @(posedge clk);
        #1;
    endtask

    task automatic cs(input logic c, input logic [2:0] ct, input logic s, input logic [2:0] stg);
        cm_valid = c; cm_tag = ct; sq_valid = s; sq_tag = stg;
        @(posedge clk);
        #1;
        cm_valid = 1'b0; sq_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] byte_a, input logic eh, input logic [31:0] ed,
                        input logic [3:0] em, input string req);
        ld_waddr = byte_a[31:2];
        @(negedge clk);
        chk(ld_hit == eh, req, 64'(ld_hit), 64'(eh));
        if (eh) chk(ld_data == ed && ld_mask == em, req, {28'd0, ld_mask, ld_data}, {28'd0, em, ed});
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] elo_d, ehi_d;
        logic [3:0]  elo_be, ehi_be;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R10 reset state
        @(negedge clk);
        chk(st_ready == 1'b1, "R10 st_ready", 64'(st_ready), 64'd1);
        chk(mem_valid == 1'b0, "R10 mem_valid", 64'(mem_valid), 64'd0);
        chk(ld_hit == 1'b0, "R10 ld_hit", 64'(ld_hit), 64'd0);
        @(posedge clk);
        #1;

        // R1 hold until commit, then drain
        clear_log();
        do_store(32'h100, 2'd3, 32'hA1B2C3D4, 1'b1, 3'd1);
        wait_cyc(4);
        chk(log_addr.size() == 0, "R1 held before commit", 64'(log_addr.size()), 64'd0);
        look(32'h100, 1'b1, 32'hA1B2C3D4, 4'hF, "R6 lookup of speculative word");
        cs(1'b1, 3'd1, 1'b0, 3'd0);
        wait_cyc(3);
        chk(log_addr.size() == 1, "R1 one write after commit", 64'(log_addr.size()), 64'd1);
        chk_log(0, 32'h100, 32'hA1B2C3D4, 4'hF, "R1 committed write");

        // R2 squash discards
        clear_log();
        do_store(32'h200, 2'd3, 32'h11112222, 1'b1, 3'd2);
        do_store(32'h208, 2'd3, 32'h33334444, 1'b1, 3'd2);
        cs(1'b0, 3'd0, 1'b1, 3'd2);
        wait_cyc(4);
        look(32'h200, 1'b0, 32'h0, 4'h0, "R2 squashed word not forwarded");
        cs(1'b1, 3'd2, 1'b0, 3'd0);
        wait_cyc(4);
        chk(log_addr.size() == 0, "R2 no write after squash", 64'(log_addr.size()), 64'd0);

        // R3 byte gathering
        clear_log();
        for (int o = 0; o < 4; o++)
            do_store(32'h300 + 32'(o), 2'd0, 32'h10 + 32'(o), 1'b1, 3'd3);
        look(32'h300, 1'b1, 32'h13121110, 4'hF, "R3 merged lookup");
        cs(1'b1, 3'd3, 1'b0, 3'd0);
        wait_cyc(4);
        chk(log_addr.size() == 1, "R3 single merged write", 64'(log_addr.size()), 64'd1);
        chk_log(0, 32'h300, 32'h13121110, 4'hF, "R3 merged contents");

        // R4 alignment sweep over every offset and length
        for (int o = 0; o < 4; o++) begin
            for (int l = 0; l < 4; l++) begin
                clear_log();
                elo_d = '0; ehi_d = '0; elo_be = '0; ehi_be = '0;
                for (int b = 0; b <= l; b++) begin
                    if (o + b < 4) begin
                        elo_d  = elo_d | (32'((b + 1) * 17) << (8 * (o + b)));
                        elo_be = elo_be | 4'(1 << (o + b));
                    end else begin
                        ehi_d  = ehi_d | (32'((b + 1) * 17) << (8 * (o + b - 4)));
                        ehi_be = ehi_be | 4'(1 << (o + b - 4));
                    end
                end
                do_store(32'h400 + 32'(o), 2'(l), 32'h44332211, 1'b0, 3'd0);
                wait_cyc(4);
                chk(log_addr.size() == ((ehi_be != 0) ? 2 : 1), "R4 write count",
                    64'(log_addr.size()), 64'((ehi_be != 0) ? 2 : 1));
                chk_log(0, 32'h400, elo_d, elo_be, "R4 lower word");
                if (ehi_be != 0) chk_log(1, 32'h404, ehi_d, ehi_be, "R4 upper word");
            end
        end

        // R5 I/O space
        clear_log();
        probe_ready(32'h8000_0040, 2'd3, 1'b1, 1'b0, "R5 speculative I/O refused");
        probe_ready(32'h7FFF_FFFE, 2'd3, 1'b1, 1'b0, "R5 crossing into I/O refused");
        probe_ready(32'h7FFF_FFF0, 2'd3, 1'b1, 1'b1, "R5 cacheable speculative accepted");
        do_store(32'h8000_0040, 2'd3, 32'hCAFEF00D, 1'b0, 3'd0);
        wait_cyc(3);
        chk_log(0, 32'h8000_0040, 32'hCAFEF00D, 4'hF, "R5 non-speculative I/O written");

        // R6 youngest forwarding, R9 mixed commit and squash, R7 hold under backpressure
        clear_log();
        do_store(32'h500, 2'd3, 32'hAAAA0001, 1'b1, 3'd4);
        do_store(32'h500, 2'd1, 32'hFFFFBBBB, 1'b1, 3'd5);
        look(32'h500, 1'b1, 32'h0000BBBB, 4'h3, "R6 youngest entry forwarded");
        look(32'h504, 1'b0, 32'h0, 4'h0, "R6 miss on other word");
        mem_ready = 1'b0;
        do_store(32'h8000_0080, 2'd3, 32'h01020304, 1'b0, 3'd0);
        look(32'h8000_0080, 1'b0, 32'h0, 4'h0, "R6 I/O word never forwarded");
        cs(1'b1, 3'd4, 1'b1, 3'd5);
        wait_cyc(3);
        @(negedge clk);
        chk(mem_valid == 1'b1 && mem_addr == 32'h500, "R7 pending write held",
            {31'd0, mem_valid, mem_addr}, {31'd0, 1'b1, 32'h500});
        @(posedge clk);
        #1;
        chk(log_addr.size() == 0, "R7 nothing drains while not ready", 64'(log_addr.size()), 64'd0);
        mem_ready = 1'b1;
        wait_cyc(6);
        chk(log_addr.size() == 2, "R9 committed kept, squashed dropped", 64'(log_addr.size()), 64'd2);
        chk_log(0, 32'h500, 32'hAAAA0001, 4'hF, "R9 committed tag written");
        chk_log(1, 32'h8000_0080, 32'h01020304, 4'hF, "R7 I/O write after it");

        // R7 younger committed store waits behind uncommitted head
        clear_log();
        do_store(32'h600, 2'd3, 32'h66666666, 1'b1, 3'd6);
        do_store(32'h604, 2'd3, 32'h77777777, 1'b0, 3'd0);
        wait_cyc(4);
        chk(log_addr.size() == 0, "R7 blocked behind uncommitted", 64'(log_addr.size()), 64'd0);
        cs(1'b1, 3'd6, 1'b0, 3'd0);
        wait_cyc(4);
        chk_log(0, 32'h600, 32'h66666666, 4'hF, "R7 order first");
        chk_log(1, 32'h604, 32'h77777777, 4'hF, "R7 order second");

        // R8 capacity
        clear_log();
        mem_ready = 1'b0;
        for (int k = 0; k < 7; k++) do_store(32'h700 + 32'(4 * k), 2'd3, 32'(k), 1'b0, 3'd0);
        probe_ready(32'h7FE, 2'd3, 1'b0, 1'b0, "R8 crossing needs two slots");
        probe_ready(32'h7F0, 2'd3, 1'b0, 1'b1, "R8 one slot left");
        do_store(32'h71C, 2'd3, 32'd7, 1'b0, 3'd0);
        probe_ready(32'h7F0, 2'd3, 1'b0, 1'b0, "R8 full refuses");
        mem_ready = 1'b1;
        wait_cyc(12);
        chk(log_addr.size() == 8, "R8 all drained", 64'(log_addr.size()), 64'd8);
        for (int k = 0; k < 8; k++) chk_log(k, 32'h700 + 32'(4 * k), 32'(k), 4'hF, "R8 drain order");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule